// File: doc/BRIEF.md
# Interrupt Request Flag Unit

This block gathers the interrupt requests of a small 8-bit microcontroller core and presents one request line for each source. Two external pins, both active low, can each be sensed either on a falling edge or on a low level. Overflow pulses from two basic timers are caught in latched flags. Five sticky flags are grouped into three further requests. A receive flag and a transmit flag form the serial request. Two timer-2 flags form the timer-2 request. A conversion-done flag forms the A/D request.

Software reaches the block through two registers. The control byte holds the sensing type of each pin, its edge flag, the run enables of both timers and their overflow flags. The auxiliary byte holds the five sticky flags. When the core vectors to a source, it returns an acknowledge together with that source's index. Only the external edge flags and the timer overflow flags clear on that acknowledge. Every other flag stays set until software writes it.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset both registers read zero, both run outputs are low and no request is raised while the pins are high.
- R2: When the type bit of an external channel is 1 (control bits 0 and 2 for channels 0 and 1), a falling pin sets its edge flag (control bits 1 and 3). The flag and its request appear three clocks after the pin falls. A rising pin sets nothing.
- R3: When the type bit is 0, the request of the channel follows the synchronized inverse of the pin, and its edge-flag position reads the live request. An acknowledge has no effect on it.
- R4: An acknowledge naming an external channel in edge mode clears that channel's edge flag.
- R5: A timer overflow pulse sets that timer's flag (control bit 5 for timer 0, bit 7 for timer 1) and raises its request. An acknowledge with that timer's index clears it.
- R6: The serial request is the OR of the receive flag (auxiliary bit 0) and the transmit flag (auxiliary bit 1). An acknowledge leaves both flags set, and only a write to the auxiliary byte clears them.
- R7: The timer-2 request is the OR of its overflow flag (auxiliary bit 2) and its external flag (auxiliary bit 3). Both flags are cleared only by software.
- R8: Each conversion-done pulse sets the A/D flag (auxiliary bit 4). The flag clears only by software.
- R9: When a hardware set meets an acknowledge clear or a software write of 0 in the same cycle, the flag ends up set.
- R10: A control write loads the type bits, the run bits (bit 4 for timer 0, bit 6 for timer 1) and the flag bits. The run bits drive the run outputs one clock later.
- R11: Request and acknowledge indices are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5, A/D = 6. An acknowledge with any other index leaves a flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 2 | External interrupt pins, active low, asynchronous |
| tmr_ovf | input | 2 | Overflow pulses from timer 0 and timer 1 |
| ser_rx_set | input | 1 | Serial receive-complete pulse |
| ser_tx_set | input | 1 | Serial transmit-complete pulse |
| t2_ovf_set | input | 1 | Timer-2 overflow pulse |
| t2_ext_set | input | 1 | Timer-2 external event pulse |
| adc_done | input | 1 | Conversion-done pulse |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read value |
| aux_wr_en | input | 1 | Auxiliary byte write strobe |
| aux_wdata | input | 5 | Auxiliary byte write data |
| aux_rdata | output | 5 | Auxiliary byte read value |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_idx | input | ACK_IDX_W | Index of the acknowledged source |
| irq_req | output | 7 | One request line per source |
| tmr_run | output | 2 | Run enables to timer 0 and timer 1 |

## Verification
Several properties are checked on every cycle. The serial and timer-2 requests must each equal the OR of their two flags. The sticky flags must survive an acknowledge, and a set pulse must always win. A timer flag must drop after a clean acknowledge, and a control write must reach the run outputs. Other behaviour depends on the pin history and on timing through the synchronizer, so only the bench scenarios show it. This covers the edge-versus-level difference, the three-clock edge latency, rising edges that set nothing, and a level request that survives an acknowledge.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   localparam int NUM_SRC  = 7;
   localparam int NUM_EXT  = 2;
   localparam int NUM_TMR  = 2;
   localparam int NUM_AUX  = 5;
   localparam int CTL_W    = 8;
   // request / acknowledge index of each source
   localparam int SRC_EXT0 = 0;
   localparam int SRC_TMR0 = 1;
   localparam int SRC_EXT1 = 2;
   localparam int SRC_TMR1 = 3;
   localparam int SRC_SER  = 4;
   localparam int SRC_T2   = 5;
   localparam int SRC_ADC  = 6;
   // auxiliary byte positions
   localparam int AUX_RX   = 0;
   localparam int AUX_TX   = 1;
   localparam int AUX_T2OV = 2;
   localparam int AUX_T2EX = 3;
   localparam int AUX_ADC  = 4;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int  STAGES   = 2,
   parameter bit  IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic pin_s
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= IDLE_VAL;
            else        chain_q <= pin;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], pin};
      end
   endgenerate

   assign pin_s = chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
   parameter bit ACK_CLEARS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic ack_hit,
   input  logic sw_wr,
   input  logic sw_val,
   output logic flag
);
   logic ack_clr;

   generate
      if (ACK_CLEARS) begin : g_ack_clear
         assign ack_clr = ack_hit;
      end else begin : g_sticky
         logic unused_ack;
         assign unused_ack = ack_hit;
         assign ack_clr    = 1'b0;
      end
   endgenerate

   // hardware set has priority over both clear paths
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      flag <= 1'b0;
      else if (hw_set) flag <= 1'b1;
      else if (ack_clr) flag <= 1'b0;
      else if (sw_wr)  flag <= sw_val;
endmodule

// File: rtl/irq_ext_chan.sv
module irq_ext_chan #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic ack_hit,
   input  logic sw_wr,
   input  logic sw_val,
   output logic req,
   output logic flag_rd
);
   logic pin_s, prev_q, fall, edge_q;

   irq_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (pin_n),
      .pin_s (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= pin_s;

   assign fall = prev_q & ~pin_s;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          edge_q <= 1'b0;
      else if (!edge_mode) edge_q <= 1'b0;
      else if (fall)       edge_q <= 1'b1;
      else if (ack_hit)    edge_q <= 1'b0;
      else if (sw_wr)      edge_q <= sw_val;

   assign req     = edge_mode ? edge_q : ~pin_s;
   assign flag_rd = req;
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
   import irq_flag_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ACK_IDX_W   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_EXT-1:0]   ext_pin_n,
   input  logic [NUM_TMR-1:0]   tmr_ovf,
   input  logic                 ser_rx_set,
   input  logic                 ser_tx_set,
   input  logic                 t2_ovf_set,
   input  logic                 t2_ext_set,
   input  logic                 adc_done,
   input  logic                 ctl_wr_en,
   input  logic [CTL_W-1:0]     ctl_wdata,
   output logic [CTL_W-1:0]     ctl_rdata,
   input  logic                 aux_wr_en,
   input  logic [NUM_AUX-1:0]   aux_wdata,
   output logic [NUM_AUX-1:0]   aux_rdata,
   input  logic                 ack_valid,
   input  logic [ACK_IDX_W-1:0] ack_idx,
   output logic [NUM_SRC-1:0]   irq_req,
   output logic [NUM_TMR-1:0]   tmr_run
);
   localparam int MIN_IDX_W = $clog2(NUM_SRC);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ACK_IDX_W < MIN_IDX_W) begin : g_bad_idx
         $error("ACK_IDX_W too narrow for the source count");
      end
   endgenerate

   // acknowledge decode
   logic [NUM_SRC-1:0] ack_hit;
   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_ack
         assign ack_hit[s] = ack_valid && (ack_idx == ACK_IDX_W'(s));
      end
   endgenerate

   // external channels: type at bit 2e, flag at bit 2e+1
   logic [NUM_EXT-1:0] ext_type_q, ext_req, ext_flag;
   genvar e;
   generate
      for (e = 0; e < NUM_EXT; e++) begin : g_ext
         localparam int TBIT = 2 * e;
         localparam int SRC  = (e == 0) ? SRC_EXT0 : SRC_EXT1;

         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)         ext_type_q[e] <= 1'b0;
            else if (ctl_wr_en) ext_type_q[e] <= ctl_wdata[TBIT];

         irq_ext_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[e]),
            .edge_mode (ext_type_q[e]),
            .ack_hit   (ack_hit[SRC]),
            .sw_wr     (ctl_wr_en),
            .sw_val    (ctl_wdata[TBIT+1]),
            .req       (ext_req[e]),
            .flag_rd   (ext_flag[e])
         );
         assign ctl_rdata[TBIT]   = ext_type_q[e];
         assign ctl_rdata[TBIT+1] = ext_flag[e];
      end
   endgenerate

   // timers: run at bit 4+2t, overflow flag at bit 5+2t
   logic [NUM_TMR-1:0] run_q, tmr_flag;
   genvar t;
   generate
      for (t = 0; t < NUM_TMR; t++) begin : g_tmr
         localparam int RBIT = 4 + 2 * t;
         localparam int SRC  = (t == 0) ? SRC_TMR0 : SRC_TMR1;

         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)         run_q[t] <= 1'b0;
            else if (ctl_wr_en) run_q[t] <= ctl_wdata[RBIT];

         irq_flag_cell #(.ACK_CLEARS(1'b1)) u_tf (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set  (tmr_ovf[t]),
            .ack_hit (ack_hit[SRC]),
            .sw_wr   (ctl_wr_en),
            .sw_val  (ctl_wdata[RBIT+1]),
            .flag    (tmr_flag[t])
         );
         assign ctl_rdata[RBIT]   = run_q[t];
         assign ctl_rdata[RBIT+1] = tmr_flag[t];
      end
   endgenerate

   assign tmr_run = run_q;

   // sticky flags, cleared only by software
   logic [NUM_AUX-1:0] aux_set;
   assign aux_set[AUX_RX]   = ser_rx_set;
   assign aux_set[AUX_TX]   = ser_tx_set;
   assign aux_set[AUX_T2OV] = t2_ovf_set;
   assign aux_set[AUX_T2EX] = t2_ext_set;
   assign aux_set[AUX_ADC]  = adc_done;

   genvar a;
   generate
      for (a = 0; a < NUM_AUX; a++) begin : g_aux
         irq_flag_cell #(.ACK_CLEARS(1'b0)) u_sticky (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set  (aux_set[a]),
            .ack_hit (ack_valid),
            .sw_wr   (aux_wr_en),
            .sw_val  (aux_wdata[a]),
            .flag    (aux_rdata[a])
         );
      end
   endgenerate

   assign irq_req[SRC_EXT0] = ext_req[0];
   assign irq_req[SRC_TMR0] = tmr_flag[0];
   assign irq_req[SRC_EXT1] = ext_req[1];
   assign irq_req[SRC_TMR1] = tmr_flag[1];
   assign irq_req[SRC_SER]  = aux_rdata[AUX_RX]   | aux_rdata[AUX_TX];
   assign irq_req[SRC_T2]   = aux_rdata[AUX_T2OV] | aux_rdata[AUX_T2EX];
   assign irq_req[SRC_ADC]  = aux_rdata[AUX_ADC];
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk
   import irq_flag_pkg::*;
#(
   parameter int ACK_IDX_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_EXT-1:0]   ext_pin_n,
   input logic [NUM_TMR-1:0]   tmr_ovf,
   input logic                 ser_rx_set,
   input logic                 ser_tx_set,
   input logic                 t2_ovf_set,
   input logic                 t2_ext_set,
   input logic                 adc_done,
   input logic                 ctl_wr_en,
   input logic [CTL_W-1:0]     ctl_wdata,
   input logic [CTL_W-1:0]     ctl_rdata,
   input logic                 aux_wr_en,
   input logic [NUM_AUX-1:0]   aux_wdata,
   input logic [NUM_AUX-1:0]   aux_rdata,
   input logic                 ack_valid,
   input logic [ACK_IDX_W-1:0] ack_idx,
   input logic [NUM_SRC-1:0]   irq_req,
   input logic [NUM_TMR-1:0]   tmr_run
);
   p_ser_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[SRC_SER] == (aux_rdata[AUX_RX] | aux_rdata[AUX_TX]));

   p_t2_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[SRC_T2] == (aux_rdata[AUX_T2OV] | aux_rdata[AUX_T2EX]));

   p_rx_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !aux_wr_en && aux_rdata[AUX_RX]) |=> aux_rdata[AUX_RX]);

   p_adc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      adc_done |=> aux_rdata[AUX_ADC]);

   p_tf0_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[0] |=> ctl_rdata[5]);

   p_tf0_ack_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_idx == ACK_IDX_W'(SRC_TMR0) && !tmr_ovf[0] && !ctl_wr_en)
      |=> !ctl_rdata[5]);

   p_run_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en |=> tmr_run == {$past(ctl_wdata[6]), $past(ctl_wdata[4])});
endmodule

bind irq_flag_unit irq_flag_unit_chk #(.ACK_IDX_W(ACK_IDX_W)) u_chk (.*);

// File: tb/irq_flag_unit_tb.sv
`timescale 1ns/1ps
module irq_flag_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_pin_n = 2'b11;
   logic [1:0] tmr_ovf = 2'b00;
   logic       ser_rx_set = 0, ser_tx_set = 0, t2_ovf_set = 0, t2_ext_set = 0, adc_done = 0;
   logic       ctl_wr_en = 0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       aux_wr_en = 0;
   logic [4:0] aux_wdata = 5'h00;
   logic [4:0] aux_rdata;
   logic       ack_valid = 0;
   logic [2:0] ack_idx = 3'd0;
   logic [6:0] irq_req;
   logic [1:0] tmr_run;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_flag_unit u_dut (.*);

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl_write(input logic [7:0] d);
      ctl_wr_en = 1; ctl_wdata = d; cyc(1); ctl_wr_en = 0;
   endtask

   task automatic aux_write(input logic [4:0] d);
      aux_wr_en = 1; aux_wdata = d; cyc(1); aux_wr_en = 0;
   endtask

   task automatic ack(input logic [2:0] idx);
      ack_valid = 1; ack_idx = idx; cyc(1); ack_valid = 0;
   endtask

   task automatic t_reset;
      chk(ctl_rdata, 8'h00, "R1 control byte");
      chk(aux_rdata, 5'h00, "R1 aux byte");
      chk(irq_req, 7'h00, "R1 requests");
      chk(tmr_run, 2'b00, "R1 run outputs");
   endtask

   task automatic t_edge;
      ctl_write(8'h05);                 // both channels edge mode
      ext_pin_n[0] = 0;
      cyc(2);
      chk(irq_req[0], 1'b0, "R2 edge not yet at two clocks");
      cyc(1);
      chk(irq_req[0], 1'b1, "R2 edge request at three clocks");
      chk(ctl_rdata[1], 1'b1, "R2 edge flag bit");
      ack(3'd2);
      chk(ctl_rdata[1], 1'b1, "R11 other index keeps ext0 flag");
      ack(3'd0);
      chk(ctl_rdata[1], 1'b0, "R4 ack clears edge flag");
      chk(irq_req[0], 1'b0, "R4 request drops while pin low");
      ext_pin_n[0] = 1;
      cyc(4);
      chk(irq_req[0], 1'b0, "R2 rising edge sets nothing");
      ext_pin_n[1] = 0; cyc(4); ext_pin_n[1] = 1; cyc(4);
      chk(irq_req[2], 1'b1, "R2 ext1 pulse latched");
      ack(3'd2);
      chk(ctl_rdata[3], 1'b0, "R4 ext1 ack clears");
   endtask

   task automatic t_level;
      ctl_write(8'h00);
      ext_pin_n[1] = 0;
      cyc(2);
      chk(irq_req[2], 1'b1, "R3 level request follows pin");
      chk(ctl_rdata[3], 1'b1, "R3 flag bit reads live request");
      ack(3'd2);
      chk(irq_req[2], 1'b1, "R3 ack does not clear level request");
      ext_pin_n[1] = 1;
      cyc(2);
      chk(irq_req[2], 1'b0, "R3 request drops with pin");
   endtask

   task automatic t_timer;
      tmr_ovf[0] = 1; cyc(1); tmr_ovf[0] = 0;
      chk(ctl_rdata[5], 1'b1, "R5 tf0 set");
      chk(irq_req[1], 1'b1, "R5 timer0 request");
      ack(3'd3);
      chk(irq_req[1], 1'b1, "R11 ack of timer1 keeps timer0");
      tmr_ovf[0] = 1; ack(3'd1); tmr_ovf[0] = 0;
      chk(ctl_rdata[5], 1'b1, "R9 set wins over ack");
      ack(3'd1);
      chk(ctl_rdata[5], 1'b0, "R5 ack clears tf0");
      tmr_ovf[1] = 1; cyc(1); tmr_ovf[1] = 0;
      chk(irq_req[3], 1'b1, "R5 timer1 request");
      ack(3'd3);
      chk(ctl_rdata[7], 1'b0, "R5 ack clears tf1");
   endtask

   task automatic t_ctl;
      ctl_write(8'h50);
      chk(tmr_run, 2'b11, "R10 run outputs");
      chk(ctl_rdata, 8'h50, "R10 readback");
      ctl_write(8'hA0);
      chk(ctl_rdata, 8'hA0, "R10 software sets overflow flags");
      chk(irq_req[3:0], 4'b1010, "R10 written flags raise requests");
      ctl_write(8'h00);
      chk(ctl_rdata, 8'h00, "R10 software clear");
   endtask

   task automatic t_serial;
      ser_rx_set = 1; cyc(1); ser_rx_set = 0;
      chk(irq_req[4], 1'b1, "R6 rx raises serial");
      ack(3'd4);
      chk(aux_rdata[0], 1'b1, "R6 ack keeps rx");
      aux_write(5'h00);
      chk(irq_req[4], 1'b0, "R6 software clears rx");
      ser_tx_set = 1; cyc(1); ser_tx_set = 0;
      chk(irq_req[4], 1'b1, "R6 tx raises serial");
      aux_write(5'h00);
      chk(aux_rdata, 5'h00, "R6 software clears tx");
   endtask

   task automatic t_timer2;
      t2_ext_set = 1; cyc(1); t2_ext_set = 0;
      chk(irq_req[5], 1'b1, "R7 ext flag raises timer2");
      ack(3'd5);
      chk(aux_rdata[3], 1'b1, "R7 ack keeps ext flag");
      t2_ovf_set = 1; cyc(1); t2_ovf_set = 0;
      aux_write(5'h04);
      chk(aux_rdata, 5'h04, "R7 overflow flag kept by write of 1");
      chk(irq_req[5], 1'b1, "R7 request from remaining flag");
      aux_write(5'h00);
      chk(irq_req[5], 1'b0, "R7 cleared");
   endtask

   task automatic t_adc;
      adc_done = 1; cyc(1); adc_done = 0;
      chk(irq_req[6], 1'b1, "R8 adc request");
      ack(3'd6);
      chk(aux_rdata[4], 1'b1, "R8 ack keeps adc");
      adc_done = 1; aux_write(5'h00); adc_done = 0;
      chk(aux_rdata[4], 1'b1, "R9 set wins over software clear");
      aux_write(5'h00);
      chk(irq_req[6], 1'b0, "R8 software clears adc");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(2);
      t_reset();
      t_edge();
      t_level();
      t_timer();
      t_ctl();
      t_serial();
      t_timer2();
      t_adc();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule